// File: doc/BRIEF.md
# Pipeline Redirect and Squash Controller

This block settles control hazards in a five-stage in-order pipeline whose fetch stage always guesses the sequential next instruction. Two events can prove that guess wrong. The execute stage can find that a branch was mispredicted. The memory stage, where the control/status register logic sits, can raise an exception and supply the trap vector. In the cycle the event is seen, the controller kills the younger instructions that entered on the wrong path. One cycle later it hands the fetch program counter the address to restart from.

The two sources sit at different depths, so each one kills a different set of stages. A mispredict kills fetch and decode. An exception also kills execute, and it stops the faulting instruction from writing back. When both happen in the same cycle, the exception wins, because it belongs to the older instruction. Any active kill also releases the decode stall, so a stall held by an instruction that is being killed cannot block the correct-path fetch.

Top module: `rsq_ctrl`

## Requirements
- R1: After reset, `redirect_valid` is 0 and `pc_sel` is 0 (sequential).
- R2: A mispredict with `ex_valid`=1 and `ex_mispredict`=1, and no exception, raises `flush_if` and `flush_id` in the same cycle. `flush_ex` and `mem_wb_kill` stay 0.
- R3: In the cycle after such a mispredict, `redirect_valid`=1, `redirect_pc` equals the `ex_target` seen in the previous cycle, and `pc_sel`=1 (branch). The redirect lasts exactly one cycle.
- R4: An exception with `mem_valid`=1 and `mem_exc`=1 raises `flush_if`, `flush_id`, `flush_ex` and `mem_wb_kill` in the same cycle.
- R5: In the cycle after an exception, `redirect_valid`=1, `redirect_pc` equals the `mem_trap_vec` seen in the previous cycle, and `pc_sel`=2 (trap).
- R6: When an exception and a mispredict occur in the same cycle, the exception's kills apply. The next cycle redirects to the trap vector with `pc_sel`=2, and the branch target is ignored.
- R7: When no flush is active, `id_stall_out` equals `id_stall_in`. `id_stall_out` is 0 whenever `flush_id` is 1.
- R8: `ex_mispredict` with `ex_valid`=0, or `mem_exc` with `mem_valid`=0, causes no flush and no redirect.
- R9: With no event, every flush output is 0, and in the next cycle `redirect_valid`=0 and `pc_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_mispredict | input | 1 | Execute-stage branch resolved against the prediction |
| ex_target | input | XLEN | Correct next PC for the branch |
| mem_valid | input | 1 | Memory stage holds a live instruction |
| mem_exc | input | 1 | Memory-stage instruction raised an exception |
| mem_trap_vec | input | XLEN | Trap vector from the status-register logic |
| id_stall_in | input | 1 | Decode stall request from the data-hazard logic |
| flush_if | output | 1 | Clear the fetch-stage valid bit |
| flush_id | output | 1 | Clear the decode-stage valid bit |
| flush_ex | output | 1 | Clear the execute-stage valid bit |
| mem_wb_kill | output | 1 | Block write-back of the faulting memory-stage instruction |
| id_stall_out | output | 1 | Decode stall after redirect override |
| redirect_valid | output | 1 | Fetch must load `redirect_pc` |
| redirect_pc | output | XLEN | Restart address |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 trap |

## Verification
An exception and a mispredict can land in the same cycle, and the same is true of a redirect and a decode stall. The bench drives an exception together with a valid mispredict that carries a different target. It then checks that `flush_ex` and `mem_wb_kill` rise, and that the following cycle carries the trap vector with `pc_sel`=2 rather than the branch target. It also holds `id_stall_in` high through each kind of redirect and checks that `id_stall_out` drops exactly while the kill is active and returns once the kill ends.

// File: rtl/rsq_pkg.sv
// Shared types for the redirect and squash controller.
package rsq_pkg;
    // Next-PC source codes; the fetch mux decodes these values.
    typedef enum logic [1:0] {
        PCSEL_SEQ    = 2'd0,
        PCSEL_BRANCH = 2'd1,
        PCSEL_TRAP   = 2'd2
    } pcsel_e;
endpackage

// File: rtl/rsq_arbiter.sv
// rsq_arbiter: qualifies the two redirect sources with their stage valid
// bits and picks the winner. The memory stage holds the older instruction,
// so its exception beats an execute-stage mispredict.
// Assumes: inputs are stable within the cycle; purely combinational.
module rsq_arbiter
    import rsq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            ex_valid,
    input  logic            ex_mispredict,
    input  logic [XLEN-1:0] ex_target,
    input  logic            mem_valid,
    input  logic            mem_exc,
    input  logic [XLEN-1:0] mem_trap_vec,
    output logic            br_fire,
    output logic            trap_fire,
    output logic            take,
    output pcsel_e          sel,
    output logic [XLEN-1:0] tgt
);
    // Qualify each source, then choose the redirect by age priority.
    always_comb begin
        trap_fire = mem_valid & mem_exc;
        br_fire   = ex_valid & ex_mispredict & ~trap_fire;
        take      = trap_fire | br_fire;
        if (trap_fire) begin
            sel = PCSEL_TRAP;
            tgt = mem_trap_vec;
        end else if (br_fire) begin
            sel = PCSEL_BRANCH;
            tgt = ex_target;
        end else begin
            sel = PCSEL_SEQ;
            tgt = ex_target;
        end
    end

    // The two sources must never both win.
    always_comb begin
        AST_SINGLE_WINNER: assert (!(br_fire && trap_fire)); // R6
    end
endmodule

// File: rtl/rsq_flush_gen.sv
// rsq_flush_gen: builds one kill bit per stage younger than the memory
// stage. Index 0 is fetch. A source at depth D kills every index below D.
// Assumes: at most one of br_fire / trap_fire is high (arbiter guarantees).
module rsq_flush_gen #(
    parameter int EX_IDX  = 2,
    parameter int MEM_IDX = 3
) (
    input  logic               br_fire,
    input  logic               trap_fire,
    output logic [MEM_IDX-1:0] flush
);
    for (genvar i = 0; i < MEM_IDX; i++) begin : g_stage
        localparam bit BY_TRAP = (i < MEM_IDX);
        localparam bit BY_BR   = (i < EX_IDX);
        // Stage i is killed by any source that sits deeper than it.
        assign flush[i] = (BY_TRAP & trap_fire) | (BY_BR & br_fire);
    end
endmodule

// File: rtl/rsq_redirect_reg.sv
// rsq_redirect_reg: holds the chosen redirect for one cycle so fetch
// restarts in the cycle after the event is seen.
// Assumes: synchronous active-low reset.
module rsq_redirect_reg
    import rsq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  pcsel_e          sel,
    input  logic [XLEN-1:0] tgt,
    output logic            redirect_valid,
    output pcsel_e          sel_q,
    output logic [XLEN-1:0] redirect_pc
);
    // Register the redirect; it is a one-cycle pulse per event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            sel_q          <= PCSEL_SEQ;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= take;
            sel_q          <= take ? sel : PCSEL_SEQ;
            if (take) redirect_pc <= tgt;
        end
    end

    // A live redirect never carries the sequential code.
    AST_VALID_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (sel_q != PCSEL_SEQ)); // R3
    AST_IDLE_IS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |-> (sel_q == PCSEL_SEQ)); // R9
endmodule

// File: rtl/rsq_ctrl.sv
// rsq_ctrl: top of the redirect and squash controller. Kills the stages
// younger than a resolving event in the same cycle, blocks write-back of
// a faulting memory-stage instruction, releases the decode stall while a
// kill is active, and presents the restart PC one cycle later.
// Assumes: stage order fetch(0), decode(1), execute(2), memory(3).
module rsq_ctrl
    import rsq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ex_valid,
    input  logic            ex_mispredict,
    input  logic [XLEN-1:0] ex_target,
    input  logic            mem_valid,
    input  logic            mem_exc,
    input  logic [XLEN-1:0] mem_trap_vec,
    input  logic            id_stall_in,
    output logic            flush_if,
    output logic            flush_id,
    output logic            flush_ex,
    output logic            mem_wb_kill,
    output logic            id_stall_out,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [1:0]      pc_sel
);
    localparam int EX_IDX  = 2;
    localparam int MEM_IDX = 3;

    logic               br_fire, trap_fire, take;
    pcsel_e             sel, sel_q;
    logic [XLEN-1:0]    tgt;
    logic [MEM_IDX-1:0] flush;

    rsq_arbiter #(.XLEN(XLEN)) u_arb (
        .ex_valid      (ex_valid),
        .ex_mispredict (ex_mispredict),
        .ex_target     (ex_target),
        .mem_valid     (mem_valid),
        .mem_exc       (mem_exc),
        .mem_trap_vec  (mem_trap_vec),
        .br_fire       (br_fire),
        .trap_fire     (trap_fire),
        .take          (take),
        .sel           (sel),
        .tgt           (tgt)
    );

    rsq_flush_gen #(.EX_IDX(EX_IDX), .MEM_IDX(MEM_IDX)) u_flush (
        .br_fire   (br_fire),
        .trap_fire (trap_fire),
        .flush     (flush)
    );

    rsq_redirect_reg #(.XLEN(XLEN)) u_reg (
        .clk            (clk),
        .rst_n          (rst_n),
        .take           (take),
        .sel            (sel),
        .tgt            (tgt),
        .redirect_valid (redirect_valid),
        .sel_q          (sel_q),
        .redirect_pc    (redirect_pc)
    );

    // Map the stage kill vector to ports; gate the stall with the decode kill.
    always_comb begin
        flush_if     = flush[0];
        flush_id     = flush[1];
        flush_ex     = flush[EX_IDX];
        mem_wb_kill  = trap_fire;
        id_stall_out = id_stall_in & ~flush_id;
        pc_sel       = sel_q;
    end

    AST_BR_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_mispredict && !(mem_valid && mem_exc)) |=>
        (redirect_valid && pc_sel == 2'd1 && redirect_pc == $past(ex_target))); // R3
    AST_TRAP_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_exc) |=>
        (redirect_valid && pc_sel == 2'd2 && redirect_pc == $past(mem_trap_vec))); // R5
    AST_EXC_KILLS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_exc) |-> (flush_if && flush_id && flush_ex && mem_wb_kill)); // R4
    AST_KILL_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ex |-> (flush_id && flush_if)); // R2
    AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_id |-> !id_stall_out); // R7
    AST_NO_EVENT_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ex_valid && ex_mispredict) && !(mem_valid && mem_exc)) |=> !redirect_valid); // R8
endmodule

// File: tb/tb_rsq_ctrl.sv
`timescale 1ns/1ps
module tb_rsq_ctrl;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ex_valid = 1'b0, ex_mispredict = 1'b0;
    logic [XLEN-1:0] ex_target = '0;
    logic            mem_valid = 1'b0, mem_exc = 1'b0;
    logic [XLEN-1:0] mem_trap_vec = '0;
    logic            id_stall_in = 1'b0;
    logic            flush_if, flush_id, flush_ex, mem_wb_kill, id_stall_out;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;
    logic [1:0]      pc_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rsq_ctrl #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .ex_mispredict(ex_mispredict), .ex_target(ex_target),
        .mem_valid(mem_valid), .mem_exc(mem_exc), .mem_trap_vec(mem_trap_vec),
        .id_stall_in(id_stall_in),
        .flush_if(flush_if), .flush_id(flush_id), .flush_ex(flush_ex),
        .mem_wb_kill(mem_wb_kill), .id_stall_out(id_stall_out),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .pc_sel(pc_sel)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive inputs on the falling edge, then let combinational outputs settle.
    task automatic drive(input logic exv, input logic mis, input logic [XLEN-1:0] tg,
                         input logic mv, input logic exc, input logic [XLEN-1:0] tv,
                         input logic st);
        @(negedge clk);
        ex_valid = exv; ex_mispredict = mis; ex_target = tg;
        mem_valid = mv; mem_exc = exc; mem_trap_vec = tv; id_stall_in = st;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 redirect_valid", redirect_valid, 0);
        check("R1 pc_sel", pc_sel, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        drive(0, 0, 32'h0, 0, 0, 32'h0, 1);
        check("R9 flush_if", flush_if, 0);
        check("R9 flush_id", flush_id, 0);
        check("R9 flush_ex", flush_ex, 0);
        check("R7 stall passes", id_stall_out, 1);
        drive(0, 0, 32'h0, 0, 0, 32'h0, 0);
        check("R9 redirect_valid", redirect_valid, 0);
        check("R9 pc_sel", pc_sel, 0);
        check("R7 stall low passes", id_stall_out, 0);
    endtask

    task automatic t_mispredict(input logic [XLEN-1:0] tg);
        drive(1, 1, tg, 0, 0, 32'hdead0000, 1);
        check("R2 flush_if", flush_if, 1);
        check("R2 flush_id", flush_id, 1);
        check("R2 flush_ex", flush_ex, 0);
        check("R2 mem_wb_kill", mem_wb_kill, 0);
        check("R7 stall released", id_stall_out, 0);
        drive(0, 0, 32'h0, 0, 0, 32'h0, 1);
        check("R3 redirect_valid", redirect_valid, 1);
        check("R3 redirect_pc", redirect_pc, tg);
        check("R3 pc_sel", pc_sel, 1);
        check("R7 stall restored", id_stall_out, 1);
        drive(0, 0, 32'h0, 0, 0, 32'h0, 0);
        check("R3 one-cycle pulse", redirect_valid, 0);
    endtask

    task automatic t_exception(input logic [XLEN-1:0] tv);
        drive(0, 0, 32'h0, 1, 1, tv, 1);
        check("R4 flush_if", flush_if, 1);
        check("R4 flush_id", flush_id, 1);
        check("R4 flush_ex", flush_ex, 1);
        check("R4 mem_wb_kill", mem_wb_kill, 1);
        check("R7 stall released on trap", id_stall_out, 0);
        drive(0, 0, 32'h0, 0, 0, 32'h0, 0);
        check("R5 redirect_valid", redirect_valid, 1);
        check("R5 redirect_pc", redirect_pc, tv);
        check("R5 pc_sel", pc_sel, 2);
        check("R5 kill ends", mem_wb_kill, 0);
    endtask

    task automatic t_both(input logic [XLEN-1:0] tg, input logic [XLEN-1:0] tv);
        drive(1, 1, tg, 1, 1, tv, 1);
        check("R6 flush_ex", flush_ex, 1);
        check("R6 mem_wb_kill", mem_wb_kill, 1);
        check("R6 stall released", id_stall_out, 0);
        drive(0, 0, 32'h0, 0, 0, 32'h0, 0);
        check("R6 redirect_valid", redirect_valid, 1);
        check("R6 redirect_pc is trap", redirect_pc, tv);
        check("R6 pc_sel trap", pc_sel, 2);
    endtask

    task automatic t_invalid();
        drive(0, 1, 32'h1111_2220, 0, 1, 32'h3333_4440, 1);
        check("R8 flush_if", flush_if, 0);
        check("R8 flush_ex", flush_ex, 0);
        check("R8 mem_wb_kill", mem_wb_kill, 0);
        check("R8 stall kept", id_stall_out, 1);
        drive(0, 0, 32'h0, 0, 0, 32'h0, 0);
        check("R8 no redirect", redirect_valid, 0);
        check("R8 pc_sel seq", pc_sel, 0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_mispredict(32'h8000_0040);
        t_mispredict(32'h0000_1ffc);
        t_exception(32'h8000_0100);
        t_both(32'h8000_0200, 32'h8000_0004);
        t_invalid();
        // Back-to-back events: mispredict then exception next cycle.
        drive(1, 1, 32'h0000_0a00, 0, 0, 32'h0, 0);
        drive(0, 0, 32'h0, 1, 1, 32'h0000_0c00, 0);
        check("R3 back-to-back branch pc", redirect_pc, 32'h0000_0a00);
        drive(0, 0, 32'h0, 0, 0, 32'h0, 0);
        check("R5 back-to-back trap pc", redirect_pc, 32'h0000_0c00);
        check("R5 back-to-back pc_sel", pc_sel, 2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule